// File: doc/BRIEF.md
# Register Write-Pending Hazard Scoreboard

The scoreboard keeps one pending-write bit for every architectural register, so that an issue stage can find read-after-write hazards before it hands an instruction to a function unit. When an instruction that writes a register is issued to a unit, the bit for its destination register is raised. The bit drops again in either of two cases. The first is when the register file write port is granted to a unit for that register. The second is when a unit finishes without producing the result it reserved at issue.

Each unit has a small tracker. At issue, the tracker captures the unit's write intent and its destination address. The captured intent is discarded as soon as the unit reports that it is idle. A done pulse without a valid result uses the captured address to release the reserved bit. Units marked as load/store class are trusted always to write, so their done pulse never releases a bit.

The issue stage queries the scoreboard with up to NUM_SRC source addresses. It receives a single hazard flag, which is combinational on the current bits. In overlapped-issue mode this flag also acts as the stall. Addresses are binary by default. A unary mode takes ready-made register masks instead.

Top module: `reg_pend_scoreboard`

## Requirements
- R1: After reset, every pending bit (pend_o) is 0 and hazard_o is 0.
- R2: A cycle with iss_valid_i high, at least one bit of iss_unit_i set and iss_wr_i high sets the pending bit of iss_dst_i from the next cycle. If iss_wr_i is low, no bit changes.
- R3: wb_en_i[u] high clears the pending bit addressed by unit u's field of wb_dst_i (bits u*AW +: AW) from the next cycle.
- R4: If a set and a clear target the same register in the same cycle, the bit ends up set.
- R5: A unit that is neither load/store class nor holding an empty captured intent is handled as follows. unit_done_i[u] high with unit_res_ok_i[u] low, while a write intent captured at that unit's issue is still held, clears the bit of the captured destination from the next cycle. With unit_res_ok_i[u] high, the done pulse clears nothing.
- R6: A unit's captured write intent is dropped in any cycle in which unit_busy_i[u] is low and the unit is not being issued to. A later done without a result then clears nothing.
- R7: A unit whose bit is set in the LDST_UNITS parameter never clears a bit through the done-without-result path.
- R8: hazard_o is high when chk_active_i is high and the pending bit is set for at least one source s with chk_src_en_i[s] high, where s takes its address from chk_src_i bits s*AW +: AW. Otherwise hazard_o is low. The flag follows the bit state in the same cycle.
- R9: In binary mode (ADDR_MODE = ADDR_BIN) an address of width $clog2(NUM_REGS) selects one register, up to register NUM_REGS-1. In unary mode (ADDR_UNARY) an address is a NUM_REGS-bit mask, and every set bit of that mask is acted on.
- R10: With OVERLAP_EN = 1, stall_o equals hazard_o, so an instruction is held while a hazard is present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| iss_valid_i | input | 1 | Issue strobe |
| iss_unit_i | input | NUM_UNITS | Unit selected for the issue |
| iss_wr_i | input | 1 | Issued instruction writes a register |
| iss_dst_i | input | AW | Destination register address of the issued instruction |
| wb_en_i | input | NUM_UNITS | Write port granted to unit, per unit |
| wb_dst_i | input | NUM_UNITS*AW | Write-back register address, per unit |
| unit_busy_i | input | NUM_UNITS | Unit busy, per unit |
| unit_done_i | input | NUM_UNITS | Unit done pulse, per unit |
| unit_res_ok_i | input | NUM_UNITS | Unit result valid, per unit |
| chk_active_i | input | 1 | A candidate instruction is being checked |
| chk_src_en_i | input | NUM_SRC | Source operand used, per source |
| chk_src_i | input | NUM_SRC*AW | Source register address, per source |
| hazard_o | output | 1 | Read-after-write hazard on a used source |
| stall_o | output | 1 | Hold issue |
| pend_o | output | NUM_REGS | Pending-write bits |

## Verification
The main function is tried with several patterns. A set followed by a write-back on the same register shows the basic set and clear. A set and a clear of the same register in one cycle shows which of the two wins. Checks on sources with the enable low, or with the check inactive, separate a real hazard from a masked one. Three done-without-result cases tell the release path apart from its two exclusions: a unit still holding its captured intent, a unit that went idle before its done pulse, and a load/store unit. A second instance in unary mode, driven with a multi-bit mask, shows the mask being passed through unchanged, while the highest binary address checks the edge of the decoder.

// File: rtl/sb_pkg.sv
package sb_pkg;
  typedef enum logic {
    ADDR_BIN   = 1'b0,
    ADDR_UNARY = 1'b1
  } addr_mode_e;
endpackage

// File: rtl/sb_addr_dec.sv
module sb_addr_dec
  import sb_pkg::*;
#(
  parameter int         NUM_REGS  = 32,
  parameter addr_mode_e ADDR_MODE = ADDR_BIN,
  parameter int         AW        = 5
) (
  input  logic                en_i,
  input  logic [AW-1:0]       addr_i,
  output logic [NUM_REGS-1:0] mask_o
);
  generate
    if (ADDR_MODE == ADDR_UNARY) begin : g_unary
      assign mask_o = en_i ? NUM_REGS'(addr_i) : '0;
    end else begin : g_bin
      always_comb begin
        mask_o = '0;
        for (int r = 0; r < NUM_REGS; r++)
          mask_o[r] = en_i && (addr_i == AW'(r));
      end
    end
  endgenerate
endmodule

// File: rtl/sb_unit_track.sv
module sb_unit_track #(
  parameter int AW      = 5,
  parameter bit IS_LDST = 1'b0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          issue_i,
  input  logic          wr_i,
  input  logic [AW-1:0] dst_i,
  input  logic          busy_i,
  input  logic          done_i,
  input  logic          res_ok_i,
  output logic          rel_o,
  output logic [AW-1:0] rel_dst_o
);
  logic          wr_q;
  logic [AW-1:0] dst_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= 1'b0;
      dst_q <= '0;
    end else if (issue_i) begin
      wr_q  <= wr_i;
      dst_q <= dst_i;
    end else if (!busy_i) begin
      wr_q  <= 1'b0;
    end
  end

  generate
    if (IS_LDST) begin : g_ldst
      assign rel_o = 1'b0;  // load/store always writes its destination
    end else begin : g_alu
      assign rel_o = done_i && wr_q && !res_ok_i;
    end
  endgenerate
  assign rel_dst_o = dst_q;
endmodule

// File: rtl/sb_bit_array.sv
module sb_bit_array #(
  parameter int NUM_REGS = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_REGS-1:0] set_i,
  input  logic [NUM_REGS-1:0] clr_i,
  output logic [NUM_REGS-1:0] bits_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) bits_o <= '0;
    else         bits_o <= (bits_o & ~clr_i) | set_i;  // set wins
  end
endmodule

// File: rtl/reg_pend_scoreboard.sv
module reg_pend_scoreboard
  import sb_pkg::*;
#(
  parameter int         NUM_REGS    = 32,
  parameter int         NUM_UNITS   = 4,
  parameter int         NUM_SRC     = 3,
  parameter addr_mode_e ADDR_MODE   = ADDR_BIN,
  parameter logic [NUM_UNITS-1:0] LDST_UNITS = 4'b1000,
  parameter bit         OVERLAP_EN  = 1'b1,
  localparam int        AW = (ADDR_MODE == ADDR_UNARY) ? NUM_REGS : $clog2(NUM_REGS)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    iss_valid_i,
  input  logic [NUM_UNITS-1:0]    iss_unit_i,
  input  logic                    iss_wr_i,
  input  logic [AW-1:0]           iss_dst_i,
  input  logic [NUM_UNITS-1:0]    wb_en_i,
  input  logic [NUM_UNITS*AW-1:0] wb_dst_i,
  input  logic [NUM_UNITS-1:0]    unit_busy_i,
  input  logic [NUM_UNITS-1:0]    unit_done_i,
  input  logic [NUM_UNITS-1:0]    unit_res_ok_i,
  input  logic                    chk_active_i,
  input  logic [NUM_SRC-1:0]      chk_src_en_i,
  input  logic [NUM_SRC*AW-1:0]   chk_src_i,
  output logic                    hazard_o,
  output logic                    stall_o,
  output logic [NUM_REGS-1:0]     pend_o
);
  logic [NUM_UNITS-1:0][NUM_REGS-1:0] u_set, u_wb, u_rel;
  logic [NUM_SRC-1:0][NUM_REGS-1:0]   s_mask;
  logic [NUM_REGS-1:0] set_mask, clr_mask, chk_mask;

  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
    logic          iss_u, rel;
    logic [AW-1:0] rel_dst;
    assign iss_u = iss_valid_i && iss_unit_i[u];

    sb_unit_track #(.AW(AW), .IS_LDST(LDST_UNITS[u])) i_trk (
      .clk_i, .rst_ni,
      .issue_i(iss_u), .wr_i(iss_wr_i), .dst_i(iss_dst_i),
      .busy_i(unit_busy_i[u]), .done_i(unit_done_i[u]),
      .res_ok_i(unit_res_ok_i[u]),
      .rel_o(rel), .rel_dst_o(rel_dst)
    );
    sb_addr_dec #(.NUM_REGS(NUM_REGS), .ADDR_MODE(ADDR_MODE), .AW(AW)) i_set_dec (
      .en_i(iss_u && iss_wr_i), .addr_i(iss_dst_i), .mask_o(u_set[u]));
    sb_addr_dec #(.NUM_REGS(NUM_REGS), .ADDR_MODE(ADDR_MODE), .AW(AW)) i_wb_dec (
      .en_i(wb_en_i[u]), .addr_i(wb_dst_i[u*AW +: AW]), .mask_o(u_wb[u]));
    sb_addr_dec #(.NUM_REGS(NUM_REGS), .ADDR_MODE(ADDR_MODE), .AW(AW)) i_rel_dec (
      .en_i(rel), .addr_i(rel_dst), .mask_o(u_rel[u]));
  end

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    sb_addr_dec #(.NUM_REGS(NUM_REGS), .ADDR_MODE(ADDR_MODE), .AW(AW)) i_chk_dec (
      .en_i(chk_src_en_i[s]), .addr_i(chk_src_i[s*AW +: AW]), .mask_o(s_mask[s]));
  end

  always_comb begin
    set_mask = '0;
    clr_mask = '0;
    chk_mask = '0;
    for (int u = 0; u < NUM_UNITS; u++) begin
      set_mask |= u_set[u];
      clr_mask |= u_wb[u] | u_rel[u];
    end
    for (int s = 0; s < NUM_SRC; s++) chk_mask |= s_mask[s];
  end

  sb_bit_array #(.NUM_REGS(NUM_REGS)) i_bits (
    .clk_i, .rst_ni, .set_i(set_mask), .clr_i(clr_mask), .bits_o(pend_o));

  assign hazard_o = chk_active_i && |(pend_o & chk_mask);

  generate
    if (OVERLAP_EN) begin : g_ovl
      assign stall_o = hazard_o;
    end else begin : g_seq
      assign stall_o = |unit_busy_i;  // no overlap: wait for all units
    end
  endgenerate
endmodule

// File: rtl/sb_checker.sv
module sb_checker #(
  parameter int NUM_REGS = 32
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic [NUM_REGS-1:0] set_mask,
  input logic [NUM_REGS-1:0] clr_mask,
  input logic [NUM_REGS-1:0] pend_o,
  input logic                chk_active_i,
  input logic                hazard_o
);
  // R2/R4: every requested set is visible next cycle, even against a clear
  p_set_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|set_mask) |=> ((pend_o & $past(set_mask)) == $past(set_mask)));

  // R3: a clear without a competing set empties the bit
  p_clr_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(clr_mask & ~set_mask)) |=> ((pend_o & $past(clr_mask & ~set_mask)) == '0));

  // R2/R3: untouched bits hold
  p_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (((pend_o ^ $past(pend_o)) & ~$past(set_mask | clr_mask)) == '0));

  // R8: no hazard when no check is active
  p_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !chk_active_i |-> !hazard_o);

  // R8: no hazard with an empty scoreboard
  p_empty_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_o == '0) |-> !hazard_o);
endmodule

bind reg_pend_scoreboard sb_checker #(.NUM_REGS(NUM_REGS)) i_sb_checker (
  .clk_i, .rst_ni, .set_mask, .clr_mask, .pend_o, .chk_active_i, .hazard_o);

// File: tb/test_reg_pend_scoreboard.sv
module test_reg_pend_scoreboard;
  import sb_pkg::*;
  localparam int NR = 32, NU = 4, NS = 3, AW = 5;
  localparam int NRU = 8;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #10 clk = ~clk;  // 50 MHz

  logic          iss_valid, iss_wr, chk_active;
  logic [NU-1:0] iss_unit, wb_en, busy, done, res_ok;
  logic [AW-1:0] iss_dst;
  logic [NU*AW-1:0] wb_dst;
  logic [NS-1:0] src_en;
  logic [NS*AW-1:0] src;
  logic          hazard, stall;
  logic [NR-1:0] pend;

  reg_pend_scoreboard i_reg_pend_scoreboard (
    .clk_i(clk), .rst_ni,
    .iss_valid_i(iss_valid), .iss_unit_i(iss_unit), .iss_wr_i(iss_wr), .iss_dst_i(iss_dst),
    .wb_en_i(wb_en), .wb_dst_i(wb_dst),
    .unit_busy_i(busy), .unit_done_i(done), .unit_res_ok_i(res_ok),
    .chk_active_i(chk_active), .chk_src_en_i(src_en), .chk_src_i(src),
    .hazard_o(hazard), .stall_o(stall), .pend_o(pend));

  // unary instance
  logic          u_valid, u_haz, u_stall;
  logic [NRU-1:0] u_dst, u_pend;
  reg_pend_scoreboard #(.NUM_REGS(NRU), .NUM_UNITS(2), .NUM_SRC(1),
                        .ADDR_MODE(ADDR_UNARY), .LDST_UNITS(2'b00)) i_reg_pend_scoreboard_unary (
    .clk_i(clk), .rst_ni,
    .iss_valid_i(u_valid), .iss_unit_i(2'b01), .iss_wr_i(1'b1), .iss_dst_i(u_dst),
    .wb_en_i(2'b00), .wb_dst_i('0),
    .unit_busy_i(2'b01), .unit_done_i(2'b00), .unit_res_ok_i(2'b00),
    .chk_active_i(1'b1), .chk_src_en_i(1'b1), .chk_src_i(u_dst),
    .hazard_o(u_haz), .stall_o(u_stall), .pend_o(u_pend));

  int n_chk = 0, n_bad = 0;

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk); #1;
    iss_valid = 0; wb_en = '0; done = '0;
  endtask

  task automatic issue(int u, logic wr, int d);
    iss_valid = 1; iss_unit = NU'(1) << u; iss_wr = wr; iss_dst = AW'(d);
  endtask

  task automatic query(int a, logic en);
    chk_active = 1; src_en = {2'b00, en}; src = {10'd0, AW'(a)}; #1;
  endtask

  task automatic t_reset();
    check("R1 pend", pend, 0);
    check("R1 hazard", hazard, 0);
  endtask

  task automatic t_set();
    issue(0, 1, 5); busy[0] = 1; cyc();
    check("R2 set r5", pend, 64'h20);
    issue(1, 0, 6); busy[1] = 1; cyc();
    check("R2 no set without write flag", pend, 64'h20);
    issue(1, 1, 31); cyc();
    check("R9 binary top address r31", pend[31], 1);
    wb_en[1] = 1; wb_dst = (NU*AW)'(31) << AW; cyc();
  endtask

  task automatic t_check();
    query(5, 1);
    check("R8 hazard on r5", hazard, 1);
    check("R10 stall follows hazard", stall, 1);
    query(5, 0);
    check("R8 disabled source", hazard, 0);
    check("R10 no stall", stall, 0);
    query(7, 1);
    check("R8 clean source", hazard, 0);
    src_en = 3'b100; src = {AW'(5), AW'(2), AW'(3)}; #1;
    check("R8 third source", hazard, 1);
    chk_active = 0; #1;
    check("R8 inactive", hazard, 0);
  endtask

  task automatic t_wb();
    wb_en[0] = 1; wb_dst = (NU*AW)'(5); cyc();
    check("R3 clear r5", pend, 0);
    query(5, 1);
    check("R3 hazard gone", hazard, 0);
    chk_active = 0;
  endtask

  task automatic t_priority();
    issue(2, 1, 9); busy[2] = 1; cyc();
    issue(1, 1, 9); wb_en[2] = 1; wb_dst = (NU*AW)'(9) << (2*AW); cyc();
    check("R4 set beats clear", pend[9], 1);
    wb_en[1] = 1; wb_dst = (NU*AW)'(9) << AW; cyc();
    check("R3 cleared r9", pend[9], 0);
  endtask

  task automatic t_done();
    issue(0, 1, 12); busy[0] = 1; cyc();
    check("R5 r12 pending", pend[12], 1);
    done[0] = 1; res_ok[0] = 0; cyc();
    check("R5 done without result clears", pend[12], 0);
    issue(1, 1, 13); busy[1] = 1; cyc();
    done[1] = 1; res_ok[1] = 1; cyc();
    res_ok = '0;
    check("R5 done with result keeps", pend[13], 1);
    wb_en[1] = 1; wb_dst = (NU*AW)'(13) << AW; cyc();
  endtask

  task automatic t_idle();
    issue(2, 1, 14); busy[2] = 0; cyc();
    cyc();  // idle: intent dropped
    done[2] = 1; cyc();
    check("R6 dropped intent keeps r14", pend[14], 1);
  endtask

  task automatic t_ldst();
    issue(3, 1, 20); busy[3] = 1; cyc();
    done[3] = 1; cyc();
    check("R7 ldst done keeps r20", pend[20], 1);
  endtask

  task automatic t_unary();
    u_dst = 8'b0010_0100; u_valid = 1;
    @(posedge clk); #1; u_valid = 0;
    check("R9 unary mask passthrough", u_pend, 8'b0010_0100);
    check("R9 unary hazard", u_haz, 1);
  endtask

  initial begin
    iss_valid = 0; iss_wr = 0; iss_unit = '0; iss_dst = '0;
    wb_en = '0; wb_dst = '0; busy = '0; done = '0; res_ok = '0;
    chk_active = 0; src_en = '0; src = '0; u_valid = 0; u_dst = '0;
    #35 rst_ni = 1;
    @(posedge clk); #1;
    t_reset();
    t_set();
    t_check();
    t_wb();
    t_priority();
    t_done();
    t_idle();
    t_ldst();
    t_unary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #100000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule